// File: doc/BRIEF.md
# Accumulator Row Shift-and-Saturate Narrowing Unit

This unit rewrites one 64-byte accumulator row in place. The row is split into equal integer lanes of 8, 16 or 32 bits. Each enabled lane is read as a signed or an unsigned number and shifted right by a 5-bit amount. The shift either truncates or rounds. The shifted value is then either clamped to a narrower signed or unsigned range or kept as it is. The result is written back into the same lane, filling the full lane width.

A 4-bit code sets two things at once: the lane width of the row and the width of the clamp range. Rounding, clamping and the signedness of the clamp range each have their own control input, so all their combinations are allowed. A byte-granular enable mask selects which lanes are rewritten. Lanes that are not enabled come back unchanged. The caller presents a row with a one-cycle valid pulse. The rewritten row appears one clock later and stays on the output until the next request.

Top module: `zrow_narrow_unit`

## Requirements
- R1: The width code picks the lane width L and the clamp width C as follows. Code 3 gives L=32 and C=16. Code 4 gives L=32 and C=32. Code 9 gives L=8 and C=8. Code 10 gives L=32 and C=8. Code 11 gives L=16 and C=8. Every other code gives L=16 and C=16. Lane k occupies row bits [k*L +: L].
- R2: When `z_signed` is 1, a lane is read as two's complement. When it is 0, the lane is read as unsigned.
- R3: When `round_en` is 0, the lane value is shifted right arithmetically by `shamt`, which is the floor of value / 2^shamt.
- R4: When `round_en` is 1 and `shamt` is greater than 0, 2^(shamt-1) is added before the shift. When `shamt` is 0, nothing is added and the value passes through unchanged.
- R5: When `sat_en` and `sat_signed` are both 1, the shifted value is clamped to [-2^(C-1), 2^(C-1)-1]. The result is stored sign-extended to L bits.
- R6: When `sat_en` is 1 and `sat_signed` is 0, the shifted value is clamped to [0, 2^C-1]. Negative values therefore become 0. The result is stored zero-extended to L bits.
- R7: When `sat_en` is 0, the lane receives the low L bits of the shifted value.
- R8: A lane is rewritten only if the `lane_en` bit of its lowest byte, bit k*L/8, is 1. Any other lane is returned bit for bit unchanged.
- R9: `out_valid` is `in_valid` delayed by one clock, and `z_out` carries the result of that request. While `in_valid` is 0, `z_out` holds its value.
- R10: After reset, `z_out` is all zero and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per row |
| z_row | input | 512 | Accumulator row to narrow |
| shamt | input | 5 | Right shift amount |
| width_code | input | 4 | Lane width / clamp width code |
| z_signed | input | 1 | Lanes read as signed (1) or unsigned (0) |
| round_en | input | 1 | Rounding shift (1) or truncating shift (0) |
| sat_en | input | 1 | Clamp (1) or plain truncation (0) |
| sat_signed | input | 1 | Signed (1) or unsigned (0) clamp range |
| lane_en | input | 64 | Byte-granular lane enable mask |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| z_out | output | 512 | Rewritten row, held until the next request |

## Verification
The bench targets the following corner cases and the wrong output each one would expose.
- Negative odd values under a truncating shift: a design that rounds toward zero gives -3 instead of -4.
- A zero shift with rounding enabled: a design that adds a rounding term when the shift is 0 changes values that should pass through.
- Negative inputs under an unsigned clamp: a wrong design stores wrapped low bits instead of 0.
- Clamped results in a wider lane: sign and zero extension into the upper lane bits must be correct.
- The two signedness flags are exercised independently, for example an 8-bit lane holding 0xFF, which must shift to 0x7F when read unsigned and to 0xFF when read signed.
- Masks that disable every other lane, unlisted width codes, and idle cycles: a wrong design touches disabled lanes, falls into the wrong lane width, or lets the output drift between requests.

// File: rtl/znu_pkg.sv
package znu_pkg;

  localparam int EXT_W  = 40;
  localparam int SH_W   = 5;
  localparam int CODE_W = 4;
  localparam int SB_W   = 6;

  typedef enum logic [1:0] {
    ZW_8  = 2'd0,
    ZW_16 = 2'd1,
    ZW_32 = 2'd2
  } zwidth_e;

  typedef struct packed {
    zwidth_e          zw;
    logic [SB_W-1:0]  sat_bits;
  } width_cfg_t;

  function automatic width_cfg_t decode_width(input logic [CODE_W-1:0] code);
    width_cfg_t c;
    case (code)
      4'd3:    begin c.zw = ZW_32; c.sat_bits = 6'd16; end
      4'd4:    begin c.zw = ZW_32; c.sat_bits = 6'd32; end
      4'd9:    begin c.zw = ZW_8;  c.sat_bits = 6'd8;  end
      4'd10:   begin c.zw = ZW_32; c.sat_bits = 6'd8;  end
      4'd11:   begin c.zw = ZW_16; c.sat_bits = 6'd8;  end
      default: begin c.zw = ZW_16; c.sat_bits = 6'd16; end
    endcase
    return c;
  endfunction

  function automatic logic signed [EXT_W-1:0] one_ext();
    return {{(EXT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic signed [EXT_W-1:0] round_shift(
    input logic signed [EXT_W-1:0] v,
    input logic [SH_W-1:0]         s,
    input logic                    rnd);
    logic signed [EXT_W-1:0] bias;
    bias = '0;
    if (rnd && (s != '0)) bias = one_ext() << (s - 5'd1);
    return (v + bias) >>> s;
  endfunction

  function automatic logic signed [EXT_W-1:0] clamp_range(
    input logic signed [EXT_W-1:0] v,
    input logic [SB_W-1:0]         sb,
    input logic                    sgn);
    logic signed [EXT_W-1:0] hi, lo;
    if (sgn) begin
      hi = (one_ext() << (sb - 6'd1)) - one_ext();
      lo = -(one_ext() << (sb - 6'd1));
    end else begin
      hi = (one_ext() << sb) - one_ext();
      lo = '0;
    end
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/znu_width_decode.sv
module znu_width_decode
  import znu_pkg::*;
(
  input  logic [CODE_W-1:0] width_code,
  output zwidth_e           zw,
  output logic [SB_W-1:0]   sat_bits
);
  width_cfg_t cfg;
  assign cfg      = decode_width(width_code);
  assign zw       = cfg.zw;
  assign sat_bits = cfg.sat_bits;
endmodule

// File: rtl/znu_lane.sv
module znu_lane
  import znu_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [LW-1:0]   din,
  input  logic            en,
  input  logic [SH_W-1:0] shamt,
  input  logic            z_signed,
  input  logic            round_en,
  input  logic            sat_en,
  input  logic            sat_signed,
  input  logic [SB_W-1:0] sat_bits,
  output logic [LW-1:0]   dout
);
  function automatic logic [LW-1:0] low_bits(input logic signed [EXT_W-1:0] v);
    return v[LW-1:0];
  endfunction

  logic signed [EXT_W-1:0] ext_val;
  logic signed [EXT_W-1:0] shifted;
  logic signed [EXT_W-1:0] clamped;
  logic [LW-1:0]           new_val;

  assign ext_val = z_signed ? {{(EXT_W-LW){din[LW-1]}}, din}
                            : {{(EXT_W-LW){1'b0}}, din};
  assign shifted = round_shift(ext_val, shamt, round_en);
  assign clamped = clamp_range(shifted, sat_bits, sat_signed);
  assign new_val = sat_en ? low_bits(clamped) : low_bits(shifted);
  assign dout    = en ? new_val : din;
endmodule

// File: rtl/znu_lane_array.sv
module znu_lane_array
  import znu_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  parameter int LW        = 16,
  localparam int LB       = LW / 8,
  localparam int NL       = ROW_BYTES / LB
) (
  input  logic [ROW_BYTES*8-1:0] row_in,
  input  logic [NL-1:0]          en,
  input  logic [SH_W-1:0]        shamt,
  input  logic                   z_signed,
  input  logic                   round_en,
  input  logic                   sat_en,
  input  logic                   sat_signed,
  input  logic [SB_W-1:0]        sat_bits,
  output logic [ROW_BYTES*8-1:0] row_out
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    znu_lane #(.LW(LW)) u_lane (
      .din        (row_in[g*LW +: LW]),
      .en         (en[g]),
      .shamt      (shamt),
      .z_signed   (z_signed),
      .round_en   (round_en),
      .sat_en     (sat_en),
      .sat_signed (sat_signed),
      .sat_bits   (sat_bits),
      .dout       (row_out[g*LW +: LW])
    );
  end
endmodule

// File: rtl/zrow_narrow_unit.sv
module zrow_narrow_unit
  import znu_pkg::*;
#(
  parameter int ROW_BYTES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ROW_BYTES*8-1:0] z_row,
  input  logic [SH_W-1:0]        shamt,
  input  logic [CODE_W-1:0]      width_code,
  input  logic                   z_signed,
  input  logic                   round_en,
  input  logic                   sat_en,
  input  logic                   sat_signed,
  input  logic [ROW_BYTES-1:0]   lane_en,
  output logic                   out_valid,
  output logic [ROW_BYTES*8-1:0] z_out
);
  localparam int ROW_BITS = ROW_BYTES * 8;
  localparam int N16      = ROW_BYTES / 2;
  localparam int N32      = ROW_BYTES / 4;

  zwidth_e           zw;
  logic [SB_W-1:0]   sat_bits;
  logic [N16-1:0]    en16;
  logic [N32-1:0]    en32;
  logic [ROW_BITS-1:0] row8, row16, row32, row_next;

  znu_width_decode u_dec (
    .width_code (width_code),
    .zw         (zw),
    .sat_bits   (sat_bits)
  );

  for (genvar k = 0; k < N16; k++) begin : g_en16
    assign en16[k] = lane_en[2*k];
  end
  for (genvar k = 0; k < N32; k++) begin : g_en32
    assign en32[k] = lane_en[4*k];
  end

  znu_lane_array #(.ROW_BYTES(ROW_BYTES), .LW(8)) u_arr8 (
    .row_in (z_row), .en (lane_en), .shamt (shamt), .z_signed (z_signed),
    .round_en (round_en), .sat_en (sat_en), .sat_signed (sat_signed),
    .sat_bits (sat_bits), .row_out (row8)
  );
  znu_lane_array #(.ROW_BYTES(ROW_BYTES), .LW(16)) u_arr16 (
    .row_in (z_row), .en (en16), .shamt (shamt), .z_signed (z_signed),
    .round_en (round_en), .sat_en (sat_en), .sat_signed (sat_signed),
    .sat_bits (sat_bits), .row_out (row16)
  );
  znu_lane_array #(.ROW_BYTES(ROW_BYTES), .LW(32)) u_arr32 (
    .row_in (z_row), .en (en32), .shamt (shamt), .z_signed (z_signed),
    .round_en (round_en), .sat_en (sat_en), .sat_signed (sat_signed),
    .sat_bits (sat_bits), .row_out (row32)
  );

  always_comb begin
    case (zw)
      ZW_8:    row_next = row8;
      ZW_32:   row_next = row32;
      default: row_next = row16;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      z_out     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) z_out <= row_next;
    end
  end
endmodule

// File: rtl/znu_checker.sv
module znu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  z_row_lo,
  input logic [3:0]  width_code,
  input logic        sat_en,
  input logic        sat_signed,
  input logic        lane_en0,
  input logic        out_valid,
  input logic [31:0] z_out_lo
);
  // R9: result strobe trails the request by one clock
  p_valid_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R9: output row holds while idle
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(z_out_lo));

  // R8: lowest byte of a disabled lane 0 comes back unchanged
  p_masked_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_en0) |=> (z_out_lo[7:0] == $past(z_row_lo)));

  // R6: unsigned clamp to 8 bits in a 32-bit lane zero-extends
  p_usat_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_en0 && sat_en && !sat_signed && width_code == 4'd10)
      |=> (z_out_lo[31:8] == 24'd0));

  // R5: signed clamp to 8 bits in a 16-bit lane sign-extends
  p_ssat_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_en0 && sat_en && sat_signed && width_code == 4'd11)
      |=> (z_out_lo[15:8] == {8{z_out_lo[7]}}));
endmodule

bind zrow_narrow_unit znu_checker u_znu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .z_row_lo   (z_row[7:0]),
  .width_code (width_code),
  .sat_en     (sat_en),
  .sat_signed (sat_signed),
  .lane_en0   (lane_en[0]),
  .out_valid  (out_valid),
  .z_out_lo   (z_out[31:0])
);

// File: tb/test_zrow_narrow_unit.sv
module test_zrow_narrow_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [511:0] z_row;
  logic [4:0]   shamt;
  logic [3:0]   width_code;
  logic         z_signed, round_en, sat_en, sat_signed;
  logic [63:0]  lane_en;
  logic         out_valid;
  logic [511:0] z_out;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  zrow_narrow_unit i_zrow_narrow_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .z_row (z_row),
    .shamt (shamt), .width_code (width_code), .z_signed (z_signed),
    .round_en (round_en), .sat_en (sat_en), .sat_signed (sat_signed),
    .lane_en (lane_en), .out_valid (out_valid), .z_out (z_out)
  );

  // Independent model of one row
  function automatic logic [511:0] model_row(
    input logic [511:0] row, input int s, input int code, input bit zs,
    input bit rnd, input bit sat, input bit ssg, input logic [63:0] mask);
    int lb, cb;
    logic [511:0] res;
    longint v, lim_hi, lim_lo;
    case (code)
      3: begin lb = 4; cb = 16; end
      4: begin lb = 4; cb = 32; end
      9: begin lb = 1; cb = 8; end
      10: begin lb = 4; cb = 8; end
      11: begin lb = 2; cb = 8; end
      default: begin lb = 2; cb = 16; end
    endcase
    res = row;
    for (int k = 0; k < 64 / lb; k++) begin
      if (mask[k*lb]) begin
        v = 0;
        for (int b = 0; b < lb; b++)
          v = v | (longint'(row[(k*lb+b)*8 +: 8]) << (8*b));
        if (zs && v[lb*8-1]) v = v - (longint'(1) << (lb*8));
        if (rnd && s > 0) v = v + (longint'(1) << (s-1));
        v = v >>> s;
        if (sat) begin
          if (ssg) begin
            lim_hi = (longint'(1) << (cb-1)) - 1;
            lim_lo = -(longint'(1) << (cb-1));
          end else begin
            lim_hi = (longint'(1) << cb) - 1;
            lim_lo = 0;
          end
          if (v > lim_hi) v = lim_hi;
          if (v < lim_lo) v = lim_lo;
        end
        for (int b = 0; b < lb; b++)
          res[(k*lb+b)*8 +: 8] = 8'(v >>> (8*b));
      end
    end
    return res;
  endfunction

  function automatic logic [511:0] rand_row();
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request; returns with the result visible on the outputs
  task automatic apply(input logic [511:0] row, input int s, input int code,
                       input bit zs, input bit rnd, input bit sat, input bit ssg,
                       input logic [63:0] mask);
    @(negedge clk);
    z_row = row; shamt = 5'(s); width_code = 4'(code);
    z_signed = zs; round_en = rnd; sat_en = sat; sat_signed = ssg;
    lane_en = mask; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 out_valid", {511'd0, out_valid}, 512'd1);
  endtask

  task automatic run_model(input string req, input logic [511:0] row, input int s,
                           input int code, input bit zs, input bit rnd, input bit sat,
                           input bit ssg, input logic [63:0] mask);
    apply(row, s, code, zs, rnd, sat, ssg, mask);
    check(req, z_out, model_row(row, s, code, zs, rnd, sat, ssg, mask));
  endtask

  task automatic t_reset();
    check("R10 z_out", z_out, 512'd0);
    check("R10 out_valid", {511'd0, out_valid}, 512'd0);
  endtask

  task automatic t_truncating_shift();
    logic [511:0] r;
    r = rand_row();
    r[31:0] = 32'hFFFF_FFF9;   // -7
    apply(r, 1, 4, 1, 0, 0, 1, '1);
    check("R3 floor of -7/2", {480'd0, z_out[31:0]}, {480'd0, 32'hFFFF_FFFC});
    run_model("R3 code4 signed shift", rand_row(), 7, 4, 1, 0, 0, 1, '1);
  endtask

  task automatic t_rounding();
    logic [511:0] r;
    r = rand_row();
    r[15:0] = 16'h0180;
    apply(r, 8, 0, 1, 1, 0, 1, '1);
    check("R4 round 0x180>>8", {496'd0, z_out[15:0]}, {496'd0, 16'h0002});
    apply(r, 8, 0, 1, 0, 0, 1, '1);
    check("R4 truncate 0x180>>8", {496'd0, z_out[15:0]}, {496'd0, 16'h0001});
    r = rand_row();
    run_model("R4 shift 0 with rounding", r, 0, 4, 1, 1, 0, 1, '1);
    check("R4 shift 0 identity", z_out, r);
    run_model("R4 R5 code3 round signed sat", rand_row(), 3, 3, 1, 1, 1, 1, '1);
  endtask

  task automatic t_signed_sat();
    logic [511:0] r;
    r = rand_row();
    r[15:0]  = 16'h7000;      // large positive -> 127
    r[31:16] = 16'h9000;      // large negative -> -128
    apply(r, 2, 11, 1, 0, 1, 1, '1);
    check("R5 clamp high", {496'd0, z_out[15:0]}, {496'd0, 16'h007F});
    check("R5 clamp low", {496'd0, z_out[31:16]}, {496'd0, 16'hFF80});
    run_model("R5 R1 code11", rand_row(), 4, 11, 1, 1, 1, 1, '1);
  endtask

  task automatic t_unsigned_sat();
    logic [511:0] r;
    r = rand_row();
    r[31:0]  = 32'h8000_0000;  // negative when signed -> 0
    r[63:32] = 32'h0001_0000;  // large -> 255
    apply(r, 0, 10, 1, 0, 1, 0, '1);
    check("R6 negative to zero", {480'd0, z_out[31:0]}, 512'd0);
    check("R6 clamp to 255", {480'd0, z_out[63:32]}, {480'd0, 32'h0000_00FF});
    run_model("R6 R2 code9 unsigned", rand_row(), 1, 9, 0, 0, 1, 0, '1);
    run_model("R6 code10 signed z", rand_row(), 5, 10, 1, 1, 1, 0, '1);
  endtask

  task automatic t_no_sat();
    logic [511:0] r;
    r = '0;
    r[7:0] = 8'hFF;
    apply(r, 1, 9, 0, 0, 0, 0, '1);
    check("R7 R2 unsigned 0xFF>>1", {504'd0, z_out[7:0]}, {504'd0, 8'h7F});
    apply(r, 1, 9, 1, 0, 0, 0, '1);
    check("R7 R2 signed 0xFF>>1", {504'd0, z_out[7:0]}, {504'd0, 8'hFF});
    run_model("R7 code10 no clamp", rand_row(), 3, 10, 1, 1, 0, 0, '1);
  endtask

  task automatic t_codes();
    run_model("R1 code0 default", rand_row(), 6, 0, 1, 1, 1, 1, '1);
    run_model("R1 code15 default", rand_row(), 9, 15, 0, 0, 1, 0, '1);
    run_model("R1 code4 sat32", rand_row(), 31, 4, 0, 1, 1, 1, '1);
  endtask

  task automatic t_mask();
    logic [511:0] r;
    r = rand_row();
    run_model("R8 alternating 32-bit lanes", r, 2, 3, 1, 1, 1, 1, 64'h0F0F_0F0F_0F0F_0F0F);
    apply(r, 2, 3, 1, 1, 1, 1, '0);
    check("R8 all disabled", z_out, r);
    run_model("R8 byte mask code9", rand_row(), 3, 9, 1, 0, 1, 0, 64'h5A5A_1234_8001_F00F);
  endtask

  task automatic t_hold();
    logic [511:0] held;
    run_model("R9 load", rand_row(), 1, 0, 1, 0, 0, 1, '1);
    held = z_out;
    z_row = rand_row(); shamt = 5'd3;
    repeat (4) @(negedge clk);
    check("R9 hold z_out", z_out, held);
    check("R9 out_valid low", {511'd0, out_valid}, 512'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; z_row = '0; shamt = '0; width_code = '0;
    z_signed = 1'b0; round_en = 1'b0; sat_en = 1'b0; sat_signed = 1'b0;
    lane_en = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_truncating_shift();
    t_rounding();
    t_signed_sat();
    t_unsigned_sat();
    t_no_sat();
    t_codes();
    t_mask();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule